// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A small synthesizable model of a pipelined synchronous static memory with a two-bit burst address counter. An access begins when one of two active-low address strobes captures the external address. One strobe serves the processor side and the other the controller side. After that, an active-low step input walks the two low address bits through a four-beat burst. The beats follow either a linear order or an interleaved order, chosen by a static strap. Read data for an address registered on one clock edge is presented after the next edge.

Three chip enables decide whether the device is selected, and they are looked at only when a new address is loaded. The processor-side strobe is gated by the primary enable and always starts a read. The controller-side strobe is not gated and may start a write. Writes are byte-lane masked. The data path is split into an input bus and an output bus, plus a drive flag that stands in for the tri-state control. An asynchronous active-low output enable and a sleep input both force that flag low. While asleep the device holds all of its state.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and after its release, `rdrive` is low and `rdata` is zero until a read completes.
- R2: When either strobe is accepted, the external address is captured with the burst count cleared. A read at that address appears on `rdata` with `rdrive` high in the cycle after the next rising edge.
- R3: If both strobes are low and `ce_pri_n` is low, only the processor-side strobe acts. That access is a read, and `bw_n` is ignored.
- R4: When `ce_pri_n` is high, a low `strb_cpu_n` is ignored completely. There is no access, and the selection and burst position are kept.
- R5: The device is selected only when `ce_pri_n`=0, `ce_hi`=1 and `ce_lo_n`=0, and these enables are sampled only on a load. While the device is deselected, step and write requests have no effect.
- R6: With `order_il`=0, each cycle with `step_n` low while selected and with no strobe moves the low two address bits to (start + count) mod 4. The count wraps after four steps.
- R7: With `order_il`=1, the low two address bits are start XOR count.
- R8: A write, which is a controller-side load or a step with any `bw_n` bit low, updates only the byte lanes i whose `bw_n[i]` is 0. Lane i is `wdata[8i+7:8i]`.
- R9: `oe_n` acts combinationally. When it is high, `rdrive` is low in the same cycle.
- R10: The first read after leaving the deselected state, including the first read after reset, leaves `rdrive` low for its output cycle.
- R11: While `sleep` is high, `rdrive` is low and all inputs except `oe_n` are ignored. Stored data and pipeline state are kept, and operation resumes when `sleep` falls.
- R12: A cycle with no accepted strobe and no step starts no access, and `rdrive` is low in the following output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| ce_pri_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| bw_n | input | LANES | Byte-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| order_il | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| wdata | input | LANES*8 | Write data |
| rdata | output | LANES*8 | Registered read data |
| rdrive | output | 1 | High when the read data should be driven onto the bus |

## Verification
The hardest state to reach is the combination of gating rules on one edge. One case is a processor strobe that the primary enable blocks while a burst is half done. The other is both strobes low together with active byte enables, where a wrong priority would quietly write. The bench builds these cases by first filling the whole array with an address-derived pattern. It then starts a burst, inserts the gated or competing strobe in the middle, and checks the following beats, so that a wrong outcome shows up as a wrong address or a changed word. Every burst start and both orders are swept with a wrap past the fourth beat. The secondary enables are toggled away during the steps to show that they are sampled only on loads.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits for a burst beat, given the start and beat count.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input burst_order_e ord);
    if (ord == ORD_INTERLEAVE) return start ^ cnt;
    return start + cnt;
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             step_n,
  input  logic             ce_pri_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             order_il,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output logic             acc_take,
  output logic             acc_valid,
  output logic             acc_wr,
  output logic             acc_first,
  output logic [AW-1:0]    acc_addr,
  output logic [LANES-1:0] acc_be
);

  logic             sel_q, sel_d;
  logic [AW-1:0]    base_q, base_d;
  logic [1:0]       cnt_q, cnt_d;
  logic             cpu_take, ctl_take, load, step, new_sel, any_bw;
  logic             wr_d, first_d;
  logic [AW-1:0]    addr_d;

  always_comb begin
    cpu_take = !strb_cpu_n && !ce_pri_n;
    ctl_take = !strb_ctl_n && !cpu_take;
    load     = cpu_take || ctl_take;
    new_sel  = !ce_pri_n && ce_hi && !ce_lo_n;
    step     = !load && !step_n && sel_q;
    any_bw   = |(~bw_n);
    sel_d    = load ? new_sel : sel_q;
    base_d   = load ? addr : base_q;
    cnt_d    = load ? 2'd0 : (step ? cnt_q + 2'd1 : cnt_q);
    acc_take = (load && new_sel) || step;
    wr_d     = !cpu_take && any_bw;
    first_d  = load && !sel_q;
    addr_d   = {base_d[AW-1:2], burst_low(base_d[1:0], cnt_d, burst_order_e'(order_il))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      acc_valid <= 1'b0;
      acc_wr    <= 1'b0;
      acc_first <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
    end else if (run) begin
      sel_q     <= sel_d;
      base_q    <= base_d;
      cnt_q     <= cnt_d;
      acc_valid <= acc_take;
      if (acc_take) begin
        acc_wr    <= wr_d;
        acc_first <= first_d;
        acc_addr  <= addr_d;
        acc_be    <= ~bw_n;
      end
    end
  end

  a_r4_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !strb_cpu_n && ce_pri_n && strb_ctl_n && step_n)
      |=> ($stable(sel_q) && $stable(cnt_q) && !acc_valid))
    else $error("R4: gated processor strobe changed state");

  a_r3_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !strb_cpu_n && !ce_pri_n) |=> !acc_wr)
    else $error("R3: processor-side load produced a write");

  a_r5_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel_q && strb_cpu_n && strb_ctl_n) |=> !acc_valid)
    else $error("R5: access while deselected");

  a_r6_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_q && !step_n && strb_cpu_n && strb_ctl_n)
      |=> (cnt_q == $past(cnt_q) + 2'd1))
    else $error("R6: burst count did not advance");

endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[g]) lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd[g*LANE_W +: LANE_W] = lane_mem[addr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    step_n,
  input  logic                    ce_pri_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    order_il,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);

  localparam int DW = LANES * LANE_W;

  logic            run;
  logic            acc_take, acc_valid, acc_wr, acc_first;
  logic [AW-1:0]   acc_addr;
  logic [LANES-1:0] acc_be;
  logic [DW-1:0]   wdata_q, arr_rd, rdata_q;
  logic            out_valid_q, out_first_q;
  logic            is_read, arr_we;

  assign run = !sleep;

  bsr_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .step_n     (step_n),
    .ce_pri_n   (ce_pri_n),
    .ce_hi      (ce_hi),
    .ce_lo_n    (ce_lo_n),
    .order_il   (order_il),
    .bw_n       (bw_n),
    .addr       (addr),
    .acc_take   (acc_take),
    .acc_valid  (acc_valid),
    .acc_wr     (acc_wr),
    .acc_first  (acc_first),
    .acc_addr   (acc_addr),
    .acc_be     (acc_be)
  );

  always_comb begin
    is_read = acc_valid && !acc_wr;
    arr_we  = run && acc_valid && acc_wr;
  end

  bsr_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .addr  (acc_addr),
    .be    (acc_be),
    .wdata (wdata_q),
    .rd    (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q     <= '0;
      rdata_q     <= '0;
      out_valid_q <= 1'b0;
      out_first_q <= 1'b0;
    end else if (run) begin
      if (acc_take) wdata_q <= wdata;
      out_valid_q <= is_read;
      out_first_q <= acc_first;
      if (is_read) rdata_q <= arr_rd;
    end
  end

  assign rdata  = rdata_q;
  assign rdrive = out_valid_q && !out_first_q && !oe_n && !sleep;

  a_r2_read_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (run && acc_valid && !acc_wr) |=> out_valid_q)
    else $error("R2: read did not reach output stage");

  a_r11_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(out_valid_q) && $stable(rdata_q)))
    else $error("R11: output stage changed during sleep");

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !acc_take) |=> !acc_valid)
    else $error("R12: access without strobe or step");

endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

  localparam int AW = 6;
  localparam int LANES = 2;
  localparam int DW = 16;
  localparam int DEPTH = 64;

  logic clk, rst_n, strb_cpu_n, strb_ctl_n, step_n, ce_pri_n, ce_hi, ce_lo_n;
  logic [LANES-1:0] bw_n;
  logic oe_n, sleep, order_il;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic rdrive;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(8)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .step_n(step_n), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .order_il(order_il),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdrive(rdrive)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drv_idle();
    strb_cpu_n = 1; strb_ctl_n = 1; step_n = 1; bw_n = '1;
    ce_pri_n = 0; ce_hi = 1; ce_lo_n = 0;
  endtask

  task automatic drv_ctl(input int a, input logic [LANES-1:0] bw, input logic [DW-1:0] d);
    drv_idle(); strb_ctl_n = 0; addr = AW'(a); bw_n = bw; wdata = d;
  endtask

  task automatic drv_cpu(input int a);
    drv_idle(); strb_cpu_n = 0; addr = AW'(a);
  endtask

  task automatic drv_step();
    drv_idle(); step_n = 0;
  endtask

  task automatic read_one(input int a, input string req);
    drv_ctl(a, '1, '0); tick();
    drv_idle(); tick();
    chk(rdrive === 1'b1, req, 32'(rdrive), 1);
    chk(rdata === model[a], req, 32'(rdata), 32'(model[a]));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; oe_n = 0; sleep = 0; order_il = 0; addr = '0; wdata = '0;
    drv_idle();
    repeat (3) tick();
    // R1: reset state
    chk(rdrive === 1'b0, "R1 rdrive", 32'(rdrive), 0);
    chk(rdata === '0, "R1 rdata", 32'(rdata), 0);
    rst_n = 1;
    tick();
    chk(rdrive === 1'b0, "R1 after release", 32'(rdrive), 0);

    // Fill whole array through the controller strobe (R8 full-lane writes)
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = pat(a);
      drv_ctl(a, '0, pat(a)); tick();
    end
    drv_idle(); tick();

    // R2: pipelined read sweep, one address per cycle
    for (int a = 0; a < DEPTH; a++) begin
      drv_ctl(a, '1, '0); tick();
      if (a > 0) begin
        chk(rdrive === 1'b1, "R2 drive", 32'(rdrive), 1);
        chk(rdata === model[a-1], "R2 data", 32'(rdata), 32'(model[a-1]));
      end
    end
    drv_idle(); tick();
    chk(rdata === model[DEPTH-1], "R2 last", 32'(rdata), 32'(model[DEPTH-1]));
    tick();
    // R12: idle cycle gives no driven output
    chk(rdrive === 1'b0, "R12 idle", 32'(rdrive), 0);

    // R6/R7: every start in both orders, five beats to cover the wrap; R5 enables off during steps
    for (int m = 0; m < 2; m++) begin
      order_il = m[0];
      for (int s = 0; s < 4; s++) begin
        int h;
        int prev;
        h = m * 4 + s + 1;
        prev = 0;
        for (int i = 0; i < 5; i++) begin
          int lo;
          if (i == 0) drv_cpu(h * 4 + s);
          else begin
            drv_step();
            if (m == 1) begin ce_hi = 0; ce_lo_n = 1; end
          end
          tick();
          if (i > 0) begin
            chk(rdrive === 1'b1, m ? "R7 R5 drive" : "R6 drive", 32'(rdrive), 1);
            chk(rdata === model[prev], m ? "R7 beat" : "R6 beat", 32'(rdata), 32'(model[prev]));
          end
          lo = m ? (s ^ (i % 4)) : ((s + i) % 4);
          prev = h * 4 + lo;
        end
        drv_idle(); tick();
        chk(rdata === model[prev], m ? "R7 wrap" : "R6 wrap", 32'(rdata), 32'(model[prev]));
        tick();
      end
    end
    order_il = 0;

    // R3: both strobes low with byte enables active: read, no write
    drv_idle(); strb_cpu_n = 0; strb_ctl_n = 0; addr = 6'd5; bw_n = '0; wdata = 16'hDEAD;
    tick();
    drv_idle(); tick();
    chk(rdrive === 1'b1, "R3 read drive", 32'(rdrive), 1);
    chk(rdata === model[5], "R3 read data", 32'(rdata), 32'(model[5]));
    tick();
    read_one(5, "R3 no write");

    // R4: gated processor strobe in the middle of a burst
    drv_cpu(40); tick();
    drv_step(); tick();
    chk(rdata === model[40], "R4 beat0", 32'(rdata), 32'(model[40]));
    drv_idle(); strb_cpu_n = 0; ce_pri_n = 1; addr = 6'h3F; tick();
    chk(rdata === model[41], "R4 beat1", 32'(rdata), 32'(model[41]));
    drv_step(); tick();
    chk(rdrive === 1'b0, "R4 no access", 32'(rdrive), 0);
    drv_idle(); tick();
    chk(rdata === model[42], "R4 burst kept", 32'(rdata), 32'(model[42]));
    tick();

    // R8: byte-lane masks
    drv_ctl(7, 2'b10, 16'hA1B2); tick();
    model[7] = {model[7][15:8], 8'hB2};
    drv_ctl(8, 2'b01, 16'hC3D4); tick();
    model[8] = {8'hC3, model[8][7:0]};
    drv_idle(); tick();
    read_one(7, "R8 lane0");
    read_one(8, "R8 lane1");

    // R5: deselect through controller strobe; write and step ignored
    drv_ctl(9, '0, 16'h0000); ce_hi = 0; tick();
    drv_step(); bw_n = '0; wdata = 16'h1111; tick();
    chk(rdrive === 1'b0, "R5 deselected", 32'(rdrive), 0);
    drv_idle(); tick();
    // R10: first read after deselect is masked
    drv_ctl(9, '1, '0); tick();
    drv_step(); tick();
    chk(rdrive === 1'b0, "R10 masked", 32'(rdrive), 0);
    chk(rdata === model[9], "R5 no write", 32'(rdata), 32'(model[9]));
    drv_idle(); tick();
    chk(rdrive === 1'b1, "R10 second read", 32'(rdrive), 1);
    chk(rdata === model[10], "R10 data", 32'(rdata), 32'(model[10]));
    // R9: asynchronous output enable
    oe_n = 1; #1;
    chk(rdrive === 1'b0, "R9 oe high", 32'(rdrive), 0);
    oe_n = 0; #1;
    chk(rdrive === 1'b1, "R9 oe low", 32'(rdrive), 1);
    tick();

    // R11: sleep
    drv_ctl(20, '1, '0); tick();
    drv_idle(); tick();
    sleep = 1; #1;
    chk(rdrive === 1'b0, "R11 asleep", 32'(rdrive), 0);
    drv_ctl(20, '0, 16'h0000); tick();
    drv_step(); tick();
    drv_idle(); sleep = 0; #1;
    chk(rdrive === 1'b1, "R11 resume drive", 32'(rdrive), 1);
    chk(rdata === model[20], "R11 resume data", 32'(rdata), 32'(model[20]));
    tick();
    read_one(20, "R11 preserved");

    done = 1;
    summary();
    $finish;
  end

endmodule